// File: doc/BRIEF.md
# UART Line Break Detector

This block sits next to a UART receiver and watches for a line break: a frame in which the line stays low for the whole character. It takes the sampled receive line and the receiver's sample tick. It also takes a pulse that marks the sampling of the stop bit, together with the decoded data, parity and stop values of that frame. It reports the break when it starts and again when it ends.

A break starts when a decoded frame has every data bit, the parity bit and the stop bit at zero. It ends once the line has stayed high for long enough. In asynchronous mode that means two consecutive ticks of the 16x oversampling clock. In synchronous mode one high sample is enough. Each of the two edges sets a sticky status bit. Software clears that bit with a clear strobe. The interrupt request is the status bit gated by a mask input. While a break is in progress, characters and framing errors from the receiver are held back.

Top module: `uart_break_detect`

## Requirements
- R1: When `frame_done` is high and the frame's data, parity and stop fields are all zero, `brk_active` and `brk_status` are both high in the following cycle.
- R2: Outside a break, a frame that has any of those fields nonzero does not start a break. In the same cycle, `char_valid` is high when the stop field is 1, and `frame_err` is high when the stop field is 0.
- R3: In asynchronous mode (`sync_mode` = 0), a break ends after two `os_tick` cycles in a row that both see `rx_line` high. Cycles without a tick do not interrupt the run. `brk_active` falls in the cycle after the second such tick, and `brk_status` is high in that same cycle.
- R4: In synchronous mode (`sync_mode` = 1), a break ends after a single `os_tick` cycle that sees `rx_line` high. `brk_active` falls and `brk_status` is high in the following cycle.
- R5: A tick that sees `rx_line` low during a break restarts the high-level count, so two further high ticks are needed in asynchronous mode.
- R6: `brk_status` stays high until a cycle in which `stat_clr` is high, and falls in the following cycle. If a break edge occurs in the same cycle as `stat_clr`, the status stays set.
- R7: `brk_irq` equals `brk_status` AND `brk_mask` within the same cycle.
- R8: While `brk_active` is high, `char_valid` and `frame_err` stay low and `frame_done` has no effect, even when the frame is all zero.
- R9: After synchronous reset, `brk_active`, `brk_status` and `brk_irq` are low.
- R10: Outside a break, ticks with `rx_line` high change neither `brk_active` nor `brk_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| os_tick | input | 1 | Oversampling tick (async) or bit sample strobe (sync) |
| rx_line | input | 1 | Sampled receive line |
| frame_done | input | 1 | Pulse when the stop bit of a frame is sampled |
| frame_data | input | DATA_W | Decoded data bits |
| frame_par | input | 1 | Decoded parity bit |
| frame_stop | input | 1 | Decoded stop bit |
| brk_mask | input | 1 | Interrupt enable for break edges |
| stat_clr | input | 1 | Status clear strobe |
| brk_active | output | 1 | Break in progress |
| brk_status | output | 1 | Sticky break edge status |
| brk_irq | output | 1 | Interrupt request |
| char_valid | output | 1 | Frame accepted as character |
| frame_err | output | 1 | Frame with low stop bit, not a break |

## Verification
`char_valid`, `frame_err` and `brk_irq` are combinational, so their expected values are due in the same cycle as the stimulus. The bench checks them shortly after it drives the inputs, before the clock edge. `brk_active` and `brk_status` each pass through one register, so they are due one edge later. The bench checks them one nanosecond after that edge, against a bench model that it advances at that same edge. Directed sequences cover the tick counts, the restart after a low tick, and a clear that collides with a break edge. Seeded random cycles then exercise both modes against the same model.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } line_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BREAK = 1'b1
    } brk_state_e;

    localparam int ASYNC_END_TICKS = 2;
    localparam int SYNC_END_TICKS  = 1;

    function automatic int end_limit(line_mode_e m, int async_n, int sync_n);
        return (m == MODE_SYNC) ? sync_n : async_n;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/brk_frame_classify.sv
module brk_frame_classify #(
    parameter int DATA_W = 8
) (
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_par,
    input  logic              frame_stop,
    input  logic              in_break,
    output logic              brk_frame,
    output logic              char_valid,
    output logic              frame_err
);
    logic all_low;

    always_comb begin
        all_low    = (frame_data == '0) && !frame_par && !frame_stop;
        brk_frame  = frame_done && !in_break && all_low;
        char_valid = frame_done && !in_break && !all_low && frame_stop;
        frame_err  = frame_done && !in_break && !all_low && !frame_stop;
    end

    // R8: nothing leaves the receiver while a break is held
    always_comb begin
        if (in_break) begin
            a_quiet_r8: assert (!char_valid && !frame_err && !brk_frame);
        end
    end
endmodule

// File: rtl/brk_end_timer.sv
module brk_end_timer
    import brk_pkg::*;
#(
    parameter int ASYNC_N = ASYNC_END_TICKS,
    parameter int SYNC_N  = SYNC_END_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       rx_line,
    input  line_mode_e mode,
    output logic       end_evt
);
    localparam int CNT_MAX = max2(ASYNC_N, SYNC_N);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] high_cnt;
    logic             hit;

    always_comb begin
        hit     = (int'(high_cnt) + 1) >= end_limit(mode, ASYNC_N, SYNC_N);
        end_evt = run && tick && rx_line && hit;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            high_cnt <= '0;
        end else if (tick) begin
            if (!rx_line || hit) high_cnt <= '0;
            else                 high_cnt <= high_cnt + 1'b1;
        end
    end

    // R5: a low tick during a break always restarts the count
    p_low_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !rx_line) |=> (high_cnt == '0));

    // R3: the count never reaches the largest threshold
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(high_cnt) < CNT_MAX);
endmodule

// File: rtl/brk_status_irq.sv
module brk_status_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    input  logic mask,
    output logic status,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          status <= 1'b0;
        else if (set_evt) status <= 1'b1;
        else if (clr)     status <= 1'b0;
    end

    assign irq = status & mask;

    // R6: status is held until a clear arrives
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> status);

    // R6: an edge wins over a clear in the same cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> status);
endmodule

// File: rtl/uart_break_detect.sv
module uart_break_detect
    import brk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ASYNC_N = ASYNC_END_TICKS,
    parameter int SYNC_N  = SYNC_END_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_par,
    input  logic              frame_stop,
    input  logic              brk_mask,
    input  logic              stat_clr,
    output logic              brk_active,
    output logic              brk_status,
    output logic              brk_irq,
    output logic              char_valid,
    output logic              frame_err
);
    brk_state_e state_q;
    line_mode_e mode;
    logic       in_break;
    logic       start_evt;
    logic       end_evt;

    assign mode       = line_mode_e'(sync_mode);
    assign in_break   = (state_q == ST_BREAK);
    assign brk_active = in_break;

    brk_frame_classify #(.DATA_W(DATA_W)) u_classify (
        .frame_done (frame_done),
        .frame_data (frame_data),
        .frame_par  (frame_par),
        .frame_stop (frame_stop),
        .in_break   (in_break),
        .brk_frame  (start_evt),
        .char_valid (char_valid),
        .frame_err  (frame_err)
    );

    brk_end_timer #(.ASYNC_N(ASYNC_N), .SYNC_N(SYNC_N)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (in_break),
        .tick    (os_tick),
        .rx_line (rx_line),
        .mode    (mode),
        .end_evt (end_evt)
    );

    brk_status_irq u_status (
        .clk     (clk),
        .rst     (rst),
        .set_evt (start_evt | end_evt),
        .clr     (stat_clr),
        .mask    (brk_mask),
        .status  (brk_status),
        .irq     (brk_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_evt) state_q <= ST_BREAK;
                ST_BREAK: if (end_evt)   state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: a break only begins on a sampled stop bit
    p_start_from_frame_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_active) |-> $past(frame_done));

    // R3: a break only ends on a tick that saw the line high
    p_end_on_high_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_active) |-> ($past(os_tick) && $past(rx_line)));

    // R10: status only rises on a break edge
    p_status_on_edge_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_status) |-> ($past(start_evt) || $past(end_evt)));
endmodule

// File: tb/tb_uart_break_detect.sv
`timescale 1ns/1ps
module tb_uart_break_detect;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          sync_mode, os_tick, rx_line, frame_done;
    logic [DW-1:0] frame_data;
    logic          frame_par, frame_stop, brk_mask, stat_clr;
    logic          brk_active, brk_status, brk_irq, char_valid, frame_err;

    always #2 clk = ~clk;

    uart_break_detect #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .os_tick(os_tick),
        .rx_line(rx_line), .frame_done(frame_done), .frame_data(frame_data),
        .frame_par(frame_par), .frame_stop(frame_stop), .brk_mask(brk_mask),
        .stat_clr(stat_clr), .brk_active(brk_active), .brk_status(brk_status),
        .brk_irq(brk_irq), .char_valid(char_valid), .frame_err(frame_err)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    // bench model of the requirements
    bit m_act = 0, m_stat = 0;
    int m_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_brk_frame();
        return frame_done && frame_data == '0 && !frame_par && !frame_stop;
    endfunction

    function automatic int lim();
        return sync_mode ? 1 : 2;
    endfunction

    task automatic drive(input bit fd, input logic [DW-1:0] d, input bit p, input bit s,
                         input bit tk, input bit rl, input bit md, input bit mk, input bit cl);
        @(negedge clk);
        frame_done = fd; frame_data = d; frame_par = p; frame_stop = s;
        os_tick = tk; rx_line = rl; sync_mode = md; brk_mask = mk; stat_clr = cl;
    endtask

    // one cycle: combinational checks before the edge, registered after it
    task automatic step(input string tag);
        bit ev_start, ev_end, e_vld, e_err, e_irq;
        #1;
        ev_start = !m_act && is_brk_frame();
        e_vld = frame_done && !m_act && !is_brk_frame() && frame_stop;
        e_err = frame_done && !m_act && !is_brk_frame() && !frame_stop;
        e_irq = m_stat && brk_mask;
        chk(char_valid == e_vld, {tag, " R2 R8 char_valid"}, char_valid, e_vld);
        chk(frame_err == e_err, {tag, " R2 R8 frame_err"}, frame_err, e_err);
        chk(brk_irq == e_irq, {tag, " R7 brk_irq"}, brk_irq, e_irq);
        ev_end = m_act && os_tick && rx_line && (m_cnt + 1 >= lim());
        @(posedge clk);
        if (m_act && os_tick) m_cnt = (!rx_line || ev_end) ? 0 : m_cnt + 1;
        if (!m_act) m_cnt = 0;
        if (ev_start) m_act = 1; else if (ev_end) m_act = 0;
        if (ev_start || ev_end) m_stat = 1; else if (stat_clr) m_stat = 0;
        #1;
        chk(brk_active == m_act, {tag, " R1 R3 R4 R5 brk_active"}, brk_active, m_act);
        chk(brk_status == m_stat, {tag, " R6 R10 brk_status"}, brk_status, m_stat);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1;
        frame_done = 0; frame_data = '0; frame_par = 0; frame_stop = 1;
        os_tick = 0; rx_line = 1; sync_mode = 0; brk_mask = 0; stat_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        // R9 reset state
        chk(!brk_active, "R9 brk_active", brk_active, 0);
        chk(!brk_status, "R9 brk_status", brk_status, 0);
        chk(!brk_irq, "R9 brk_irq", brk_irq, 0);

        // R2: ordinary frames
        drive(1, 8'h41, 0, 1, 0, 1, 0, 0, 0); step("R2 good");
        drive(1, 8'h10, 0, 0, 0, 0, 0, 0, 0); step("R2 ferr");
        drive(1, 8'h00, 1, 0, 0, 0, 0, 0, 0); step("R2 parity high");
        chk(!brk_active, "R2 no break on parity", brk_active, 0);

        // R10: high ticks outside a break
        drive(0, 0, 0, 1, 1, 1, 0, 1, 0); step("R10");
        drive(0, 0, 0, 1, 1, 1, 0, 1, 0); step("R10");
        chk(!brk_active && !brk_status, "R10 idle", brk_status, 0);

        // R1: all-low frame starts the break
        drive(1, 8'h00, 0, 0, 0, 0, 0, 0, 0); step("R1 start");
        chk(brk_active && brk_status, "R1 start seen", brk_active, 1);
        // R7 masking
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); #1;
        chk(!brk_irq, "R7 masked", brk_irq, 0); step("R7 mask0");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0); #1;
        chk(brk_irq, "R7 unmasked", brk_irq, 1); step("R7 mask1");
        // R6 clear
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1); step("R6 clr");
        chk(!brk_status, "R6 cleared", brk_status, 0);
        // R8 frames during break
        drive(1, 8'h55, 0, 1, 0, 0, 0, 1, 0); #1;
        chk(!char_valid, "R8 char held", char_valid, 0); step("R8");
        drive(1, 8'h00, 0, 0, 0, 0, 0, 1, 0); step("R8 zero frame");
        chk(!brk_status, "R8 no new start", brk_status, 0);

        // R3 / R5 async end
        drive(0, 0, 0, 0, 1, 1, 0, 1, 0); step("R3 high1");
        drive(0, 0, 0, 0, 1, 0, 0, 1, 0); step("R5 low");
        drive(0, 0, 0, 0, 1, 1, 0, 1, 0); step("R5 high1");
        chk(brk_active, "R5 restart", brk_active, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0); step("R3 no tick");
        drive(0, 0, 0, 0, 1, 1, 0, 1, 1); step("R3 high2 with clr");
        chk(!brk_active, "R3 ended", brk_active, 0);
        chk(brk_status, "R6 set beats clr", brk_status, 1);

        // R4 sync end
        drive(0, 0, 0, 0, 0, 1, 1, 0, 1); step("R4 clr");
        drive(1, 8'h00, 0, 0, 0, 0, 1, 0, 0); step("R4 start");
        drive(0, 0, 0, 0, 1, 1, 1, 0, 1); step("R4 one high");
        chk(!brk_active && brk_status, "R4 ended", brk_active, 0);

        // seeded random mix
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            bit zf;
            zf = ($urandom % 6) == 0;
            drive(($urandom % 4) == 0,
                  zf ? 8'h00 : DW'($urandom),
                  zf ? 1'b0 : 1'($urandom),
                  zf ? 1'b0 : 1'($urandom),
                  ($urandom % 3) == 0,
                  ($urandom % 4) != 0,
                  (i / 500) % 2 == 1,
                  1'($urandom),
                  ($urandom % 8) == 0);
            step("rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule